// File: doc/BRIEF.md
# Dual-Slot Receive Buffer Controller

This block sits between the receive side of an Ethernet MAC and a pair of frame buffers in memory. The host owns two buffer slots. It arms a slot by writing the "loaded" code into that slot's state register. When a frame arrives on the byte-stream input, the controller claims an armed slot. It writes a rebuilt frame into that slot's buffer: an eight-byte preamble and start delimiter, then the payload, zero padding up to the minimum payload size, and finally a CRC-32 frame check sequence. It then stores the total byte count and marks the slot pending.

A level interrupt stays high while any slot is pending. The host reads the count, consumes the buffer and writes the state register back to empty, or re-arms the slot. When no slot is armed, the controller back-pressures the input and holds the frame at the start marker until the host arms a slot. If a frame cannot fit in one slot buffer, the controller consumes it and discards it, and no host-visible state changes.

Top module: `rx_pingpong_ctrl`

## Requirements
- R1: After reset all four host registers read zero, `irq_o` is low, `in_ready_o` is low and `buf_we_o` is low.
- R2: The host register at word address 0 is the slot 0 state (bits 1:0), address 1 is the slot 0 count, address 2 is the slot 1 state and address 3 is the slot 1 count. The state codes are 0 for empty, 1 for loaded and 2 for pending. A host write is visible on `host_rdata_o` from the next cycle.
- R3: A frame starting with `in_sop_i` goes to slot 0 if slot 0 is loaded, and otherwise to slot 1 if slot 1 is loaded. If neither slot is loaded, `in_ready_o` stays low, the frame waits and no register changes.
- R4: Buffer bytes 0 to 6 hold 0x55 and byte 7 holds 0xD5. The payload bytes follow in arrival order from offset 8.
- R5: A payload shorter than 60 bytes is followed by zero bytes up to a padded length of 60.
- R6: The four bytes after the padded payload hold the CRC-32 of the padded payload, least significant byte first. The CRC uses the reflected polynomial 0xEDB88320, starts from all ones and is inverted at the end. The preamble is not included.
- R7: When the frame is complete, the slot count becomes the padded payload length plus 12 and the slot state becomes pending (2).
- R8: A frame whose payload length plus 12 exceeds the slot buffer size is consumed through `in_eop_i`, and the slot state and count are left unchanged.
- R9: `irq_o` is high exactly while at least one slot state is pending. It is updated in the cycle after a frame completes and in the cycle after a host state write.
- R10: Input bytes are taken only on cycles with `in_valid_i` and `in_ready_o` both high. `in_ready_o` stays low while the preamble is written, so the first payload byte is presented for 9 cycles before it is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Input byte valid |
| in_ready_o | output | 1 | Input byte accepted this cycle when high together with valid |
| in_data_i | input | 8 | Input payload byte |
| in_sop_i | input | 1 | Marks the first byte of a frame |
| in_eop_i | input | 1 | Marks the last byte of a frame |
| buf_we_o | output | 1 | Buffer write strobe |
| buf_slot_o | output | 1 | Slot targeted by the buffer write |
| buf_addr_o | output | clog2(BUF_BYTES) | Byte offset within the slot buffer |
| buf_data_o | output | 8 | Byte written to the buffer |
| host_we_i | input | 1 | Host register write strobe |
| host_addr_i | input | 2 | Host register word address |
| host_wdata_i | input | HOST_W | Host write data |
| host_rdata_o | output | HOST_W | Host read data for `host_addr_i` (combinational) |
| irq_o | output | 1 | Receive interrupt level |

## Verification
A slot-selection or state-register fault appears within one cycle of the host write or of frame completion: the wrong slot goes pending, `irq_o` takes the wrong level, or a state read returns a code other than 2. Sequencing faults in the preamble, padding or checksum stages do not show up until the frame is complete. They then appear as wrong buffer contents at fixed offsets or a wrong count, so every payload length from 1 to the fit limit is swept against a bench-computed image of the buffer. A fault in the overflow handling shows only after the end marker, as a state or count that changed when it should not have, so oversized frames are followed by a register read and a normal frame.

// File: rtl/rxpp_pkg.sv
package rxpp_pkg;

  typedef enum logic [1:0] {
    SLOT_EMPTY   = 2'd0,
    SLOT_LOADED  = 2'd1,
    SLOT_PENDING = 2'd2
  } slot_state_e;

  typedef enum logic [2:0] {
    FR_IDLE,
    FR_PRE,
    FR_PAY,
    FR_PAD,
    FR_FCS,
    FR_DONE
  } fr_state_e;

  localparam logic [7:0]  PRE_BYTE    = 8'h55;
  localparam logic [7:0]  SFD_BYTE    = 8'hD5;
  localparam int unsigned PRE_LEN     = 8;
  localparam int unsigned OVERHEAD    = 12;
  localparam int unsigned MIN_PAYLOAD = 60;
  localparam logic [31:0] CRC_POLY    = 32'hEDB88320;

  function automatic logic [31:0] crc_byte(input logic [31:0] c_in, input logic [7:0] d);
    logic [31:0] c;
    c = c_in ^ {24'h0, d};
    for (int b = 0; b < 8; b++) begin
      c = c[0] ? ((c >> 1) ^ CRC_POLY) : (c >> 1);
    end
    return c;
  endfunction

endpackage

// File: rtl/rxpp_crc32.sv
module rxpp_crc32 import rxpp_pkg::*; (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        init_i,
  input  logic        en_i,
  input  logic [7:0]  data_i,
  output logic [31:0] fcs_o
);
  logic [31:0] crc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     crc_q <= '1;
    else if (init_i) crc_q <= '1;
    else if (en_i)   crc_q <= crc_byte(crc_q, data_i);
  end

  assign fcs_o = ~crc_q;

endmodule

// File: rtl/rxpp_slot_regs.sv
module rxpp_slot_regs import rxpp_pkg::*; #(
  parameter int unsigned HOST_W = 32,
  parameter int unsigned LEN_W  = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [1:0]        addr_i,
  input  logic [HOST_W-1:0] wdata_i,
  output logic [HOST_W-1:0] rdata_o,
  input  logic              done_i,
  input  logic              done_slot_i,
  input  logic [LEN_W-1:0]  done_len_i,
  output logic [1:0]        loaded_o,
  output logic              irq_o
);
  localparam int unsigned NSLOT = 2;

  logic [1:0]        st_q  [NSLOT];
  logic [HOST_W-1:0] cnt_q [NSLOT];
  logic [1:0]        pend;

  // completion outranks a same-cycle host write to the same slot
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < NSLOT; s++) begin
        st_q[s]  <= SLOT_EMPTY;
        cnt_q[s] <= '0;
      end
    end else begin
      for (int s = 0; s < NSLOT; s++) begin
        if (done_i && (done_slot_i == s[0])) begin
          st_q[s]  <= SLOT_PENDING;
          cnt_q[s] <= HOST_W'(done_len_i);
        end else if (we_i && (addr_i == {s[0], 1'b0})) begin
          st_q[s] <= wdata_i[1:0];
        end else if (we_i && (addr_i == {s[0], 1'b1})) begin
          cnt_q[s] <= wdata_i;
        end
      end
    end
  end

  always_comb begin
    for (int s = 0; s < NSLOT; s++) begin
      loaded_o[s] = (st_q[s] == SLOT_LOADED);
      pend[s]     = (st_q[s] == SLOT_PENDING);
    end
  end

  assign irq_o   = |pend;
  assign rdata_o = addr_i[0] ? cnt_q[addr_i[1]] : HOST_W'(st_q[addr_i[1]]);

  // R7
  done0_pending_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && !done_slot_i) |=> (st_q[0] == SLOT_PENDING));
  // R7
  done1_pending_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && done_slot_i) |=> (st_q[1] == SLOT_PENDING));

endmodule

// File: rtl/rxpp_framer.sv
module rxpp_framer import rxpp_pkg::*; #(
  parameter int unsigned BUF_BYTES = 2048,
  parameter int unsigned ADDR_W    = $clog2(BUF_BYTES),
  parameter int unsigned LEN_W     = $clog2(BUF_BYTES + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  input  logic [7:0]        in_data_i,
  input  logic              in_sop_i,
  input  logic              in_eop_i,
  input  logic [1:0]        loaded_i,
  output logic              buf_we_o,
  output logic              buf_slot_o,
  output logic [ADDR_W-1:0] buf_addr_o,
  output logic [7:0]        buf_data_o,
  output logic              done_o,
  output logic              done_slot_o,
  output logic [LEN_W-1:0]  done_len_o
);
  localparam logic [LEN_W-1:0] MAX_PAY_L = LEN_W'(BUF_BYTES - OVERHEAD);
  localparam logic [LEN_W-1:0] MIN_L     = LEN_W'(MIN_PAYLOAD);
  localparam logic [LEN_W-1:0] PRE_L     = LEN_W'(PRE_LEN);
  localparam logic [LEN_W-1:0] OVH_L     = LEN_W'(OVERHEAD);
  localparam logic [LEN_W-1:0] ONE_L     = LEN_W'(1);

  fr_state_e        st_q;
  logic             slot_q;
  logic [LEN_W-1:0] pay_q;
  logic [2:0]       idx_q;
  logic             drop_q;

  logic        take, fits;
  logic        crc_init, crc_en;
  logic [7:0]  crc_data;
  logic [31:0] fcs;

  rxpp_crc32 u_crc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .init_i (crc_init),
    .en_i   (crc_en),
    .data_i (crc_data),
    .fcs_o  (fcs)
  );

  always_comb begin
    in_ready_o = (st_q == FR_PAY);
    take       = in_valid_i && in_ready_o;
    fits       = (pay_q < MAX_PAY_L) && !drop_q;
    crc_init   = (st_q == FR_PRE);
    crc_en     = 1'b0;
    crc_data   = 8'h00;
    buf_we_o   = 1'b0;
    buf_data_o = 8'h00;
    buf_addr_o = '0;
    unique case (st_q)
      FR_PRE: begin
        buf_we_o   = 1'b1;
        buf_addr_o = ADDR_W'(idx_q);
        buf_data_o = (idx_q == 3'd7) ? SFD_BYTE : PRE_BYTE;
      end
      FR_PAY: begin
        if (take && fits) begin
          buf_we_o   = 1'b1;
          buf_addr_o = ADDR_W'(PRE_L + pay_q);
          buf_data_o = in_data_i;
          crc_en     = 1'b1;
          crc_data   = in_data_i;
        end
      end
      FR_PAD: begin
        buf_we_o   = 1'b1;
        buf_addr_o = ADDR_W'(PRE_L + pay_q);
        crc_en     = 1'b1;
      end
      FR_FCS: begin
        buf_we_o   = 1'b1;
        buf_addr_o = ADDR_W'(PRE_L + pay_q + LEN_W'(idx_q));
        buf_data_o = fcs[{idx_q[1:0], 3'b000} +: 8];
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= FR_IDLE;
      slot_q <= 1'b0;
      pay_q  <= '0;
      idx_q  <= '0;
      drop_q <= 1'b0;
    end else begin
      unique case (st_q)
        FR_IDLE: begin
          if (in_valid_i && in_sop_i && (loaded_i != 2'b00)) begin
            slot_q <= !loaded_i[0];
            pay_q  <= '0;
            idx_q  <= '0;
            drop_q <= 1'b0;
            st_q   <= FR_PRE;
          end
        end
        FR_PRE: begin
          idx_q <= idx_q + 3'd1;
          if (idx_q == 3'd7) st_q <= FR_PAY;
        end
        FR_PAY: begin
          if (take) begin
            if (fits) pay_q  <= pay_q + ONE_L;
            else      drop_q <= 1'b1;
            if (in_eop_i) begin
              idx_q <= '0;
              if (!fits)                    st_q <= FR_IDLE;
              else if (pay_q + ONE_L < MIN_L) st_q <= FR_PAD;
              else                          st_q <= FR_FCS;
            end
          end
        end
        FR_PAD: begin
          pay_q <= pay_q + ONE_L;
          if (pay_q == MIN_L - ONE_L) st_q <= FR_FCS;
        end
        FR_FCS: begin
          idx_q <= idx_q + 3'd1;
          if (idx_q == 3'd3) st_q <= FR_DONE;
        end
        default: st_q <= FR_IDLE;
      endcase
    end
  end

  assign buf_slot_o  = slot_q;
  assign done_o      = (st_q == FR_DONE);
  assign done_slot_o = slot_q;
  assign done_len_o  = pay_q + OVH_L;

  // R3
  no_start_unarmed_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == FR_IDLE && loaded_i == 2'b00) |=> (st_q == FR_IDLE));
  // R3
  prefer_slot0_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == FR_IDLE && in_valid_i && in_sop_i && loaded_i[0]) |=> (st_q == FR_PRE && !slot_q));
  // R5
  pad_reaches_min_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == FR_FCS) |-> (pay_q >= MIN_L));
  // R8
  done_len_fits_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (done_len_o <= LEN_W'(BUF_BYTES)));

endmodule

// File: rtl/rx_pingpong_ctrl.sv
module rx_pingpong_ctrl import rxpp_pkg::*; #(
  parameter int unsigned BUF_BYTES = 2048,
  parameter int unsigned HOST_W    = 32,
  localparam int unsigned ADDR_W   = $clog2(BUF_BYTES),
  localparam int unsigned LEN_W    = $clog2(BUF_BYTES + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  input  logic [7:0]        in_data_i,
  input  logic              in_sop_i,
  input  logic              in_eop_i,
  output logic              buf_we_o,
  output logic              buf_slot_o,
  output logic [ADDR_W-1:0] buf_addr_o,
  output logic [7:0]        buf_data_o,
  input  logic              host_we_i,
  input  logic [1:0]        host_addr_i,
  input  logic [HOST_W-1:0] host_wdata_i,
  output logic [HOST_W-1:0] host_rdata_o,
  output logic              irq_o
);
  logic [1:0]       loaded;
  logic             done;
  logic             done_slot;
  logic [LEN_W-1:0] done_len;

  rxpp_framer #(
    .BUF_BYTES (BUF_BYTES),
    .ADDR_W    (ADDR_W),
    .LEN_W     (LEN_W)
  ) u_framer (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .in_valid_i  (in_valid_i),
    .in_ready_o  (in_ready_o),
    .in_data_i   (in_data_i),
    .in_sop_i    (in_sop_i),
    .in_eop_i    (in_eop_i),
    .loaded_i    (loaded),
    .buf_we_o    (buf_we_o),
    .buf_slot_o  (buf_slot_o),
    .buf_addr_o  (buf_addr_o),
    .buf_data_o  (buf_data_o),
    .done_o      (done),
    .done_slot_o (done_slot),
    .done_len_o  (done_len)
  );

  rxpp_slot_regs #(
    .HOST_W (HOST_W),
    .LEN_W  (LEN_W)
  ) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .we_i        (host_we_i),
    .addr_i      (host_addr_i),
    .wdata_i     (host_wdata_i),
    .rdata_o     (host_rdata_o),
    .done_i      (done),
    .done_slot_i (done_slot),
    .done_len_i  (done_len),
    .loaded_o    (loaded),
    .irq_o       (irq_o)
  );

  // R9
  done_raises_irq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done |=> irq_o);

endmodule

// File: tb/tb_rx_pingpong_ctrl.sv
module tb_rx_pingpong_ctrl;
  localparam int BUF = 128;
  localparam int AW  = $clog2(BUF);
  localparam int MAXPAY = BUF - 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic          in_valid = 1'b0, in_sop = 1'b0, in_eop = 1'b0;
  logic [7:0]    in_data = 8'h00;
  logic          in_ready_o;
  logic          buf_we_o, buf_slot_o;
  logic [AW-1:0] buf_addr_o;
  logic [7:0]    buf_data_o;
  logic          host_we = 1'b0;
  logic [1:0]    host_addr = 2'd0;
  logic [31:0]   host_wdata = 32'h0;
  logic [31:0]   host_rdata_o;
  logic          irq_o;

  rx_pingpong_ctrl #(.BUF_BYTES(BUF), .HOST_W(32)) dut (
    .clk_i(clk), .rst_ni(rst_n),
    .in_valid_i(in_valid), .in_ready_o(in_ready_o), .in_data_i(in_data),
    .in_sop_i(in_sop), .in_eop_i(in_eop),
    .buf_we_o(buf_we_o), .buf_slot_o(buf_slot_o), .buf_addr_o(buf_addr_o), .buf_data_o(buf_data_o),
    .host_we_i(host_we), .host_addr_i(host_addr), .host_wdata_i(host_wdata),
    .host_rdata_o(host_rdata_o), .irq_o(irq_o)
  );

  logic [7:0] mem [2][BUF];
  always @(posedge clk) if (buf_we_o) mem[buf_slot_o][buf_addr_o] <= buf_data_o;

  logic [7:0] pay [256];
  int n_chk = 0, n_fail = 0;
  int first_wait;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic host_wr(input int a, input logic [31:0] d);
    @(negedge clk);
    host_we = 1'b1; host_addr = 2'(a); host_wdata = d;
    @(negedge clk);
    host_we = 1'b0;
  endtask

  task automatic host_rd(input int a, output logic [31:0] d);
    @(negedge clk);
    host_addr = 2'(a);
    #1 d = host_rdata_o;
  endtask

  task automatic fill(input int len, input int seed);
    for (int i = 0; i < len; i++) pay[i] = 8'((seed + i * 29 + len * 3) & 255);
  endtask

  task automatic send_frame(input int len);
    first_wait = 0;
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      in_valid = 1'b1; in_data = pay[i]; in_sop = (i == 0); in_eop = (i == len - 1);
      while (!in_ready_o) begin
        @(negedge clk);
        if (i == 0) first_wait++;
      end
      @(posedge clk);
    end
    @(negedge clk);
    in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0;
  endtask

  function automatic logic [31:0] crc_ref(input int len, input int padlen);
    logic [31:0] c;
    logic [7:0]  b;
    logic        fb;
    c = 32'hFFFF_FFFF;
    for (int i = 0; i < padlen; i++) begin
      b = (i < len) ? pay[i] : 8'h00;
      for (int k = 0; k < 8; k++) begin
        fb = c[0] ^ b[k];
        c  = c >> 1;
        if (fb) c = c ^ 32'hEDB8_8320;
      end
    end
    return ~c;
  endfunction

  task automatic wait_pending(input int slot);
    logic [31:0] d;
    for (int t = 0; t < 300; t++) begin
      host_rd(slot * 2, d);
      if (d == 32'd2) break;
    end
  endtask

  task automatic check_frame(input int slot, input int len);
    int padlen, bad;
    logic [31:0] d, crc, got;
    padlen = (len < 60) ? 60 : len;
    host_rd(slot * 2, d);
    chk(d == 32'd2, "R7", "slot state pending", d, 2);
    host_rd(slot * 2 + 1, d);
    chk(d == 32'(padlen + 12), "R7", "slot count", d, 32'(padlen + 12));
    bad = 0;
    for (int k = 0; k < 7; k++) if (mem[slot][k] !== 8'h55) bad++;
    if (mem[slot][7] !== 8'hD5) bad++;
    chk(bad == 0, "R4", "preamble/SFD mismatches", 32'(bad), 0);
    bad = 0;
    for (int i = 0; i < len; i++) if (mem[slot][8 + i] !== pay[i]) bad++;
    chk(bad == 0, "R4", "payload mismatches", 32'(bad), 0);
    bad = 0;
    for (int i = len; i < padlen; i++) if (mem[slot][8 + i] !== 8'h00) bad++;
    chk(bad == 0, "R5", "pad mismatches", 32'(bad), 0);
    crc = crc_ref(len, padlen);
    got = {mem[slot][8 + padlen + 3], mem[slot][8 + padlen + 2],
           mem[slot][8 + padlen + 1], mem[slot][8 + padlen]};
    chk(got === crc, "R6", "FCS", got, crc);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] d;
    bit ok;
    repeat (5) @(negedge clk);
    chk(buf_we_o == 1'b0, "R1", "buf_we in reset", 32'(buf_we_o), 0);
    rst_n = 1'b1;

    // R1 reset state
    for (int a = 0; a < 4; a++) begin
      host_rd(a, d);
      chk(d == 32'd0, "R1", "register after reset", d, 0);
    end
    chk(irq_o == 1'b0, "R1", "irq after reset", 32'(irq_o), 0);
    chk(in_ready_o == 1'b0, "R1", "ready after reset", 32'(in_ready_o), 0);

    // R2 register map readback
    host_wr(1, 32'hA5A5_1234);
    host_rd(1, d); chk(d == 32'hA5A5_1234, "R2", "slot0 count readback", d, 32'hA5A5_1234);
    host_wr(3, 32'h0F0F_0042);
    host_rd(3, d); chk(d == 32'h0F0F_0042, "R2", "slot1 count readback", d, 32'h0F0F_0042);
    host_wr(2, 32'd1);
    host_rd(2, d); chk(d == 32'd1, "R2", "slot1 state readback", d, 1);
    host_rd(0, d); chk(d == 32'd0, "R2", "slot0 state untouched", d, 0);
    host_wr(2, 32'd0);

    // R3 no slot armed: held off
    fill(70, 1);
    @(negedge clk);
    in_valid = 1'b1; in_sop = 1'b1; in_data = pay[0]; in_eop = 1'b0;
    ok = 1'b1;
    for (int t = 0; t < 20; t++) begin
      @(negedge clk);
      if (in_ready_o) ok = 1'b0;
    end
    chk(ok, "R3", "ready while no slot armed", 32'(!ok), 0);
    host_rd(0, d); chk(d == 32'd0, "R3", "slot0 state while unarmed", d, 0);
    host_rd(2, d); chk(d == 32'd0, "R3", "slot1 state while unarmed", d, 0);
    host_wr(2, 32'd1);
    send_frame(70);
    wait_pending(1);
    check_frame(1, 70);
    host_rd(0, d); chk(d == 32'd0, "R3", "slot0 untouched when only slot1 armed", d, 0);
    host_wr(2, 32'd0);

    // R3 both armed: slot 0 preferred, then slot 1
    host_wr(0, 32'd1);
    host_wr(2, 32'd1);
    fill(64, 2);
    send_frame(64);
    chk(first_wait == 9, "R10", "cycles first byte held", 32'(first_wait), 9);
    wait_pending(0);
    check_frame(0, 64);
    host_rd(2, d); chk(d == 32'd1, "R3", "slot1 still loaded", d, 1);
    chk(irq_o == 1'b1, "R9", "irq with slot0 pending", 32'(irq_o), 1);
    fill(61, 3);
    send_frame(61);
    wait_pending(1);
    check_frame(1, 61);
    host_wr(0, 32'd0);
    chk(irq_o == 1'b1, "R9", "irq with slot1 still pending", 32'(irq_o), 1);
    host_wr(2, 32'd0);
    chk(irq_o == 1'b0, "R9", "irq after both cleared", 32'(irq_o), 0);

    // length sweep through the fit limit
    for (int len = 1; len <= MAXPAY; len++) begin
      host_wr(0, 32'd1);
      fill(len, len * 5);
      send_frame(len);
      wait_pending(0);
      check_frame(0, len);
      chk(irq_o == 1'b1, "R9", "irq after frame", 32'(irq_o), 1);
      host_wr(0, 32'd0);
      chk(irq_o == 1'b0, "R9", "irq after host clear", 32'(irq_o), 0);
    end

    // R8 oversize frames
    for (int rep = 0; rep < 2; rep++) begin
      int len;
      len = (rep == 0) ? MAXPAY + 1 : 200;
      host_wr(1, 32'h0000_0BAD);
      host_wr(0, 32'd1);
      fill(len, 77 + rep);
      send_frame(len);
      repeat (100) @(negedge clk);
      host_rd(0, d); chk(d == 32'd1, "R8", "state after oversize", d, 1);
      host_rd(1, d); chk(d == 32'h0BAD, "R8", "count after oversize", d, 32'h0BAD);
      chk(irq_o == 1'b0, "R8", "irq after oversize", 32'(irq_o), 0);
    end
    fill(10, 9);
    send_frame(10);
    wait_pending(0);
    check_frame(0, 10);
    host_wr(0, 32'd0);

    finish_run();
  end

endmodule